// File: doc/BRIEF.md
# Partial-Product Carry Accumulator

This block sits behind a half-word column multiplier. That multiplier leaves 4N-1 overlapping partial words. Each partial word is up to 47 bits wide, and partial word k has weight 2^(16k). The block folds them into a full-size product of 2N 32-bit words. It emits one product word per cycle, least significant first, so the stream can feed a reduction stage directly.

Each output cycle w handles the following terms:
- The even partial word 2w is added in full.
- The part of odd word 2w-1 above bit 16 is added at its natural offset.
- The low 16 bits of odd word 2w+1 are added in the upper half of the word.
- The 16-bit carry from the previous cycle fills the lower half of the word.

The low 32 bits of the sum leave the block as the product word. The bits above them become the carry for the next cycle. A start pulse in the idle state launches a sequence. A done pulse marks the final word.

Top module: `pp_carry_accum`

## Requirements
- R1: After reset, busy, word_valid and done are all low.
- R2: Start is sampled high while the block is idle. From that cycle, busy is high for exactly 2N cycles. Product word w appears with word_valid high in the (w+2)-th cycle, counting the start cycle as the first.
- R3: Partial word k occupies si_flat[47k+46:47k]. Word w is the low 32 bits of the sum of four terms: si[2w], si[2w-1] shifted right by 16, si[2w+1][15:0] placed at bits 31:16, and the carry held in bits 15:0.
- R4: For w = 0 there is no si[2w-1] term. For w = 2N-1 there is no si[2w+1] term.
- R5: The carry for the next cycle is bits 47:32 of the sum. It is zero for the first word of every sequence.
- R6: Suppose the partial words come from a real N×32-bit by N×32-bit product. Then the concatenated output words, word 0 lowest, equal that product exactly. This holds for operands that drive every carry to its maximum.
- R7: done is high for one cycle, together with the last word (word_idx = 2N-1). busy is low in that same cycle.
- R8: A start pulse while busy is ignored. The running sequence keeps its word order and its values.
- R9: Within a sequence, word_idx starts at 0 and rises by one on each valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (honoured only when idle) |
| si_flat | input | (4N-1)*47 | Partial words, word k at bits 47k+46:47k, held stable while busy |
| busy | output | 1 | Sequence in progress |
| word_valid | output | 1 | word_out holds a product word |
| word_idx | output | log2(2N) | Position of the current product word |
| word_out | output | 32 | Product word |
| done | output | 1 | Last product word of the sequence |

## Verification
On every cycle, the assertions check the following sequencing behaviour:
- The valid stream follows busy one cycle later.
- word_idx steps by one within a sequence.
- done coincides with the last index and with the drop of busy.
- The carry is clear when a sequence begins.
- A start pulse during a run changes nothing.

The arithmetic itself can only be shown by the bench scenarios. The bench compares every output word with the true product of operand pairs: zero, one times a value, all-ones operands that saturate the carry path, and random pairs. It also repeats a random product with a stray start in the middle.

// File: rtl/pp_carry_accum.sv
module pp_carry_accum #(
  parameter int N      = 8,
  parameter int WORD_W = 32,
  parameter int PART_W = 47
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [(4*N-1)*PART_W-1:0]     si_flat,
  output logic                          busy,
  output logic                          word_valid,
  output logic [$clog2(2*N)-1:0]        word_idx,
  output logic [WORD_W-1:0]             word_out,
  output logic                          done
);
  localparam int HALF_W   = WORD_W / 2;
  localparam int NUM_PART = 4 * N - 1;
  localparam int NUM_OUT  = 2 * N;
  localparam int IDX_W    = $clog2(NUM_OUT);
  localparam int SUM_W    = WORD_W + HALF_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OUT - 1);

  logic [PART_W-1:0] part [NUM_PART];

  for (genvar k = 0; k < NUM_PART; k++) begin : g_unpack
    assign part[k] = si_flat[k*PART_W +: PART_W];
  end

  logic              busy_q;
  logic [IDX_W-1:0]  w_q;
  logic [HALF_W-1:0] carry_q;

  wire first = (w_q == '0);
  wire last  = (w_q == LAST);

  wire [IDX_W:0] k_even  = {w_q, 1'b0};
  wire [IDX_W:0] k_below = first ? k_even : k_even - (IDX_W+1)'(1);
  wire [IDX_W:0] k_above = last  ? k_even : k_even + (IDX_W+1)'(1);

  wire [PART_W-1:0] below_hi = first ? '0 : (part[k_below] >> HALF_W);
  wire [HALF_W-1:0] above_lo = last  ? '0 : part[k_above][HALF_W-1:0];

  wire [SUM_W-1:0] sum = SUM_W'(part[k_even]) + SUM_W'(below_hi)
                       + SUM_W'({above_lo, carry_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      w_q        <= '0;
      carry_q    <= '0;
      word_valid <= 1'b0;
      word_idx   <= '0;
      word_out   <= '0;
      done       <= 1'b0;
    end else begin
      word_valid <= busy_q;
      done       <= busy_q && last;
      if (busy_q) begin
        word_out <= sum[WORD_W-1:0];
        word_idx <= w_q;
        carry_q  <= sum[SUM_W-1:WORD_W];
        w_q      <= w_q + IDX_W'(1);
        if (last) busy_q <= 1'b0;
      end else if (start) begin
        busy_q  <= 1'b1;
        w_q     <= '0;
        carry_q <= '0;
      end
    end
  end

  assign busy = busy_q;

  // R2
  valid_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> word_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !word_valid);
  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !done) |=> (word_valid && word_idx == $past(word_idx) + IDX_W'(1)));
  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_valid && word_idx == LAST && !busy_q));
  // R5
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (carry_q == '0 && w_q == '0));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && w_q == $past(w_q) + IDX_W'(1)));
endmodule

// File: tb/pp_carry_accum_tb_top.sv
module pp_carry_accum_tb_top;
  localparam int N      = 8;
  localparam int PART_W = 47;
  localparam int NP     = 4 * N - 1;
  localparam int NO     = 2 * N;
  localparam int OPW    = 32 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NP*PART_W-1:0] si_flat = '0;
  logic busy, word_valid, done;
  logic [$clog2(NO)-1:0] word_idx;
  logic [31:0] word_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pp_carry_accum #(.N(N), .WORD_W(32), .PART_W(PART_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .si_flat(si_flat),
    .busy(busy), .word_valid(word_valid), .word_idx(word_idx),
    .word_out(word_out), .done(done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    for (int k = 0; k < NP; k++) begin
      logic [PART_W-1:0] acc = '0;
      for (int i = 0; i < NO; i++) begin
        int j = k - i;
        if (j >= 0 && j < NO)
          acc += PART_W'(a[16*i +: 16]) * PART_W'(b[16*j +: 16]);
      end
      si_flat[k*PART_W +: PART_W] = acc;
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R9, optional stray start for R8
  task automatic run(input string name, input logic [OPW-1:0] a,
                     input logic [OPW-1:0] b, input bit stray);
    logic [2*OPW-1:0] prod = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    load(a, b);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({name, " R2 busy"}, 64'(busy), 64'd1);
    for (int w = 0; w < NO; w++) begin
      if (stray && w == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({name, " R2 valid"}, 64'(word_valid), 64'd1);
      chk({name, " R9 idx"}, 64'(word_idx), 64'(w));
      chk({name, stray ? " R8 word" : " R6 word"}, 64'(word_out), 64'(prod[32*w +: 32]));
      chk({name, " R7 done"}, 64'(done), 64'(w == NO - 1));
      if (w == NO - 1) chk({name, " R7 busy"}, 64'(busy), 64'd0);
    end
    @(negedge clk);
    chk({name, " R2 idle"}, 64'(word_valid | busy | done), 64'd0);
  endtask

  function automatic logic [OPW-1:0] rnd();
    logic [OPW-1:0] v;
    for (int i = 0; i < N; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 valid", 64'(word_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run("zero R5", '0, '0, 1'b0);
    run("one R3", OPW'(1), 256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0, 1'b0);
    run("max R4 R5", '1, '1, 1'b0);
    run("edge R4", {16'hffff, {(OPW-32){1'b0}}, 16'hffff}, {16'hffff, {(OPW-16){1'b1}}}, 1'b0);
    for (int r = 0; r < 6; r++) run("rand R6", rnd(), rnd(), 1'b0);
    run("stray R8", rnd(), rnd(), 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule